// File: doc/BRIEF.md
# Display Window and Orientation Commander

This block turns a request to open a drawing window on a 176 by 220 panel into the controller command bytes that set it up. A request gives a first and last column, a first and last row, a two-bit rotation code and a colour-order (BGR) flag. The block emits a stream of bytes. Each byte has a flag that marks it as a command or as a parameter. A serial word sender downstream takes the stream and adds the data/command bit. Once the stream ends, the pixel path may start writing data.

The block remembers the orientation it last sent. It sends the memory-access-control command (36h and one parameter) only when the rotation or BGR setting differs from that value, or when no orientation has been sent since reset. Every request then sends three commands:

- the column range, 2Ah followed by four parameters;
- the row range, 2Bh followed by four parameters;
- the memory-write command, 2Ch, with no parameters.

Each coordinate goes out as a zero byte followed by its 8-bit value. If a coordinate lies past the panel edge, the block clamps it to the last valid index.

The request side has a plain valid/ready handshake, where ready is the inverse of busy. The byte side is valid/ready with back-pressure. A byte counts as taken on a clock edge where both `cmd_valid` and `cmd_ready` are high. While valid is high and ready is low, the byte and its flag stay stable. The sink may hold ready low for any number of cycles.

Top module: `win_cmd_top`

## Requirements
- R1: After reset `busy` and `cmd_valid` are low and `req_ready` is high.
- R2: A request is taken only on a clock edge where `req_valid` is high and `busy` is low. A request raised while busy is ignored: the stream in progress does not change and no second stream follows it.
- R3: The first accepted request after reset always starts with the orientation command. The stream is command byte 36h (flag high), then its parameter byte (flag low), and then the window bytes.
- R4: The orientation parameter has bit 7 as row flip, bit 6 as column flip, bit 5 as row/column exchange and bit 3 as BGR. All other bits are zero. Rotation code 0 (0°) sets no flip or exchange bit. Code 1 (90°) sets bits 7 and 5. Code 2 (180°) sets bits 7 and 6. Code 3 (270°) sets bits 6 and 5.
- R5: When a request has the same rotation and BGR as the last orientation sent, the stream starts directly at the column command.
- R6: The column part is command 2Ah, then the parameters 00h, first column, 00h, last column.
- R7: The row part follows the column part in the same form: command 2Bh, then 00h, first row, 00h, last row.
- R8: The stream always ends with command 2Ch (flag high), and no parameter follows it.
- R9: A column above 175 is sent as 175, and a row above 219 is sent as 219. Values inside the panel pass through unchanged.
- R10: While `cmd_valid` is high and `cmd_ready` is low, `cmd_byte` and `cmd_is_cmd` hold their values. The stream advances by exactly one byte for each handshake.
- R11: `busy` stays high until the 2Ch byte is taken and is low in the cycle after. A new request can be accepted from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Window request present |
| req_ready | output | 1 | Block can take a request (inverse of busy) |
| col_first | input | COORD_W | First column of the window |
| col_last | input | COORD_W | Last column of the window |
| row_first | input | COORD_W | First row of the window |
| row_last | input | COORD_W | Last row of the window |
| rot_code | input | 2 | 0: 0°, 1: 90°, 2: 180°, 3: 270° |
| bgr | input | 1 | Colour order flag |
| cmd_valid | output | 1 | Byte on `cmd_byte` is valid |
| cmd_ready | input | 1 | Word sender takes the byte |
| cmd_byte | output | 8 | Command or parameter byte |
| cmd_is_cmd | output | 1 | High for command bytes, low for parameters |
| busy | output | 1 | A command stream is in progress |

## Verification
The bench targets four kinds of error:

- **Orientation skip.** A design that compared against the wrong stored orientation would repeat 36h on a request with the same orientation, or would drop it when only the BGR flag changed. Both cases are exercised, along with every rotation code.
- **Clamping.** Coordinates just past the panel edge and at the maximum input value are requested. A design missing the clamp, or clamping against the wrong dimension, would put 200 or 250 on the wire.
- **Back-pressure.** The sink is stalled for several cycles at a time and alternates its ready signal. A design that advanced without a handshake, or changed the byte while stalled, would show skipped or altered bytes.
- **Requests while busy.** A request is raised in the middle of a stream. It must neither disturb that stream nor produce a second one.

// File: rtl/win_cmd_pkg.sv
package win_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int STEP_W = 4;

  localparam logic [BYTE_W-1:0] CMD_ORIENT  = 8'h36;
  localparam logic [BYTE_W-1:0] CMD_COL_SET = 8'h2A;
  localparam logic [BYTE_W-1:0] CMD_ROW_SET = 8'h2B;
  localparam logic [BYTE_W-1:0] CMD_MEM_WR  = 8'h2C;

  // stream positions; the order is behaviour
  localparam logic [STEP_W-1:0] ST_ORIENT_CMD = 4'd0;
  localparam logic [STEP_W-1:0] ST_ORIENT_PAR = 4'd1;
  localparam logic [STEP_W-1:0] ST_COL_CMD    = 4'd2;
  localparam logic [STEP_W-1:0] ST_COL_HI0    = 4'd3;
  localparam logic [STEP_W-1:0] ST_COL_LO0    = 4'd4;
  localparam logic [STEP_W-1:0] ST_COL_HI1    = 4'd5;
  localparam logic [STEP_W-1:0] ST_COL_LO1    = 4'd6;
  localparam logic [STEP_W-1:0] ST_ROW_CMD    = 4'd7;
  localparam logic [STEP_W-1:0] ST_ROW_HI0    = 4'd8;
  localparam logic [STEP_W-1:0] ST_ROW_LO0    = 4'd9;
  localparam logic [STEP_W-1:0] ST_ROW_HI1    = 4'd10;
  localparam logic [STEP_W-1:0] ST_ROW_LO1    = 4'd11;
  localparam logic [STEP_W-1:0] ST_MEM_WR     = 4'd12;

  typedef enum logic [1:0] {
    ROT_0   = 2'd0,
    ROT_90  = 2'd1,
    ROT_180 = 2'd2,
    ROT_270 = 2'd3
  } rot_e;

  // orientation parameter bit positions
  localparam int OB_ROW_FLIP = 7;
  localparam int OB_COL_FLIP = 6;
  localparam int OB_EXCHANGE = 5;
  localparam int OB_BGR      = 3;
endpackage

// File: rtl/win_clamp.sv
module win_clamp #(
  parameter int IN_W  = 8,
  parameter int LIMIT = 176
) (
  input  logic [IN_W-1:0] coord_in,
  output logic [7:0]      coord_out
);
  localparam int MAX_IDX = LIMIT - 1;
  localparam logic [IN_W-1:0] MAX_IN = IN_W'(MAX_IDX);

  logic [IN_W-1:0] sat;

  always_comb begin
    if (coord_in > MAX_IN) sat = MAX_IN;
    else                   sat = coord_in;
    coord_out = sat[7:0];
  end
endmodule

// File: rtl/orient_enc.sv
module orient_enc
  import win_cmd_pkg::*;
(
  input  logic [1:0]        rot_code,
  input  logic              bgr,
  output logic [BYTE_W-1:0] param
);
  always_comb begin
    param = '0;
    param[OB_BGR] = bgr;
    unique case (rot_e'(rot_code))
      ROT_0:   ;
      ROT_90:  begin param[OB_ROW_FLIP] = 1'b1; param[OB_EXCHANGE] = 1'b1; end
      ROT_180: begin param[OB_ROW_FLIP] = 1'b1; param[OB_COL_FLIP] = 1'b1; end
      ROT_270: begin param[OB_COL_FLIP] = 1'b1; param[OB_EXCHANGE] = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/win_seq.sv
module win_seq
  import win_cmd_pkg::*;
#(
  parameter logic [STEP_W-1:0] LAST_STEP = ST_MEM_WR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STEP_W-1:0] start_step,
  input  logic              advance,
  output logic              busy,
  output logic [STEP_W-1:0] step
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (start && !busy) begin
      busy <= 1'b1;
      step <= start_step;
    end else if (busy && advance) begin
      if (step == LAST_STEP) begin
        busy <= 1'b0;
        step <= '0;
      end else begin
        step <= step + 1'b1;
      end
    end
  end

  // R11
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && advance && step == LAST_STEP |=> !busy);

  // R10
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !advance |=> busy && $stable(step));
endmodule

// File: rtl/win_cmd_top.sv
module win_cmd_top
  import win_cmd_pkg::*;
#(
  parameter int COORD_W  = 8,
  parameter int NUM_COLS = 176,
  parameter int NUM_ROWS = 220
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [COORD_W-1:0] col_first,
  input  logic [COORD_W-1:0] col_last,
  input  logic [COORD_W-1:0] row_first,
  input  logic [COORD_W-1:0] row_last,
  input  logic [1:0]         rot_code,
  input  logic               bgr,
  output logic               cmd_valid,
  input  logic               cmd_ready,
  output logic [7:0]         cmd_byte,
  output logic               cmd_is_cmd,
  output logic               busy
);
  localparam int NCOORD = 4;
  localparam int FIRST_ROW_IDX = 2;

  logic [COORD_W-1:0] raw  [NCOORD];
  logic [7:0]         clmp [NCOORD];
  logic [7:0]         held [NCOORD];
  logic [BYTE_W-1:0]  orient_new, orient_q;
  logic               orient_known;
  logic               accept, need_orient;
  logic [STEP_W-1:0]  step;

  assign raw[0] = col_first;
  assign raw[1] = col_last;
  assign raw[2] = row_first;
  assign raw[3] = row_last;

  for (genvar g = 0; g < NCOORD; g++) begin : g_clamp
    win_clamp #(
      .IN_W (COORD_W),
      .LIMIT((g < FIRST_ROW_IDX) ? NUM_COLS : NUM_ROWS)
    ) i_clamp (
      .coord_in (raw[g]),
      .coord_out(clmp[g])
    );
  end

  orient_enc i_orient (
    .rot_code(rot_code),
    .bgr     (bgr),
    .param   (orient_new)
  );

  assign accept      = req_valid && !busy;
  assign need_orient = !orient_known || (orient_new != orient_q);
  assign req_ready   = !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      orient_known <= 1'b0;
      orient_q     <= '0;
      for (int i = 0; i < NCOORD; i++) held[i] <= '0;
    end else if (accept) begin
      orient_known <= 1'b1;
      orient_q     <= orient_new;
      for (int i = 0; i < NCOORD; i++) held[i] <= clmp[i];
    end
  end

  win_seq #(.LAST_STEP(ST_MEM_WR)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (accept),
    .start_step(need_orient ? ST_ORIENT_CMD : ST_COL_CMD),
    .advance   (cmd_ready),
    .busy      (busy),
    .step      (step)
  );

  assign cmd_valid = busy;

  always_comb begin
    cmd_byte   = 8'h00;
    cmd_is_cmd = 1'b0;
    unique case (step)
      ST_ORIENT_CMD: begin cmd_byte = CMD_ORIENT;  cmd_is_cmd = 1'b1; end
      ST_ORIENT_PAR: cmd_byte = orient_q;
      ST_COL_CMD:    begin cmd_byte = CMD_COL_SET; cmd_is_cmd = 1'b1; end
      ST_COL_LO0:    cmd_byte = held[0];
      ST_COL_LO1:    cmd_byte = held[1];
      ST_ROW_CMD:    begin cmd_byte = CMD_ROW_SET; cmd_is_cmd = 1'b1; end
      ST_ROW_LO0:    cmd_byte = held[2];
      ST_ROW_LO1:    cmd_byte = held[3];
      ST_MEM_WR:     begin cmd_byte = CMD_MEM_WR;  cmd_is_cmd = 1'b1; end
      default:       cmd_byte = 8'h00;
    endcase
  end

  // R10
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_byte) && $stable(cmd_is_cmd));

  // R8
  end_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(cmd_byte) == CMD_MEM_WR && $past(cmd_is_cmd) && $past(cmd_ready));

  // R3
  first_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> cmd_is_cmd && (cmd_byte == CMD_ORIENT || cmd_byte == CMD_COL_SET));

  // R4
  orient_zero_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && step == ST_ORIENT_PAR |-> cmd_byte[4] == 1'b0 && cmd_byte[2:0] == 3'b000);

  // R9
  col_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (step == ST_COL_LO0 || step == ST_COL_LO1) |-> 32'(cmd_byte) < NUM_COLS);

  // R9
  row_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && (step == ST_ROW_LO0 || step == ST_ROW_LO1) |-> 32'(cmd_byte) < NUM_ROWS);

  // R2
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(cmd_ready && step == ST_MEM_WR) |=> busy);
endmodule

// File: tb/test_win_cmd_top.sv
module test_win_cmd_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [7:0] col_first = '0, col_last = '0, row_first = '0, row_last = '0;
  logic [1:0] rot_code = '0;
  logic       bgr = 1'b0;
  logic       cmd_valid;
  logic       cmd_ready = 1'b0;
  logic [7:0] cmd_byte;
  logic       cmd_is_cmd;
  logic       busy;

  int n_checks = 0;
  int n_fails  = 0;

  logic [7:0] exp_b [16];
  logic       exp_c [16];
  int         exp_n;
  logic [7:0] last_orient;
  logic       orient_sent = 1'b0;

  always #4 clk = ~clk;

  win_cmd_top i_win_cmd_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .col_first(col_first), .col_last(col_last), .row_first(row_first), .row_last(row_last),
    .rot_code(rot_code), .bgr(bgr), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_byte(cmd_byte), .cmd_is_cmd(cmd_is_cmd), .busy(busy)
  );

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] clampv(input logic [7:0] v, input int lim);
    return (int'(v) > lim - 1) ? 8'(lim - 1) : v;
  endfunction

  function automatic logic [7:0] orient_of(input logic [1:0] r, input logic b);
    logic [7:0] p;
    p = {4'b0000, b, 3'b000};
    case (r)
      2'd1: p = p | 8'hA0;
      2'd2: p = p | 8'hC0;
      2'd3: p = p | 8'h60;
      default: ;
    endcase
    return p;
  endfunction

  task automatic push(input logic [7:0] b, input logic c);
    exp_b[exp_n] = b;
    exp_c[exp_n] = c;
    exp_n++;
  endtask

  // mode 0: always ready, 1: alternate, 2: stall three then ready
  task automatic run_req(input logic [7:0] cf, input logic [7:0] cl, input logic [7:0] rf,
                         input logic [7:0] rl, input logic [1:0] r, input logic b,
                         input int mode, input logic inject, input string tag);
    logic [7:0] op;
    logic [7:0] held_b;
    logic       held_v;
    int idx;
    int cyc;
    logic rdy;
    exp_n = 0;
    op = orient_of(r, b);
    if (!orient_sent || op != last_orient) begin
      push(8'h36, 1'b1); push(op, 1'b0);   // R3 R4
    end
    orient_sent = 1'b1;
    last_orient = op;
    push(8'h2A, 1'b1); push(8'h00, 1'b0); push(clampv(cf, 176), 1'b0);   // R6
    push(8'h00, 1'b0); push(clampv(cl, 176), 1'b0);
    push(8'h2B, 1'b1); push(8'h00, 1'b0); push(clampv(rf, 220), 1'b0);   // R7
    push(8'h00, 1'b0); push(clampv(rl, 220), 1'b0);
    push(8'h2C, 1'b1);                                                     // R8

    chk(req_ready == 1'b1, {"R11 ready before ", tag}, int'(req_ready), 1);
    col_first = cf; col_last = cl; row_first = rf; row_last = rl;
    rot_code = r; bgr = b; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    idx = 0; cyc = 0; held_v = 1'b0; held_b = '0;
    while (idx < exp_n && cyc < 300) begin
      if (inject && cyc == 2) begin
        req_valid = 1'b1; col_first = 8'd1; rot_code = 2'd3; bgr = 1'b1;   // R2
      end else begin
        req_valid = 1'b0;
      end
      case (mode)
        1: rdy = (cyc % 2) == 1;
        2: rdy = (cyc % 4) == 3;
        default: rdy = 1'b1;
      endcase
      chk(cmd_valid == 1'b1, {"R11 valid during ", tag}, int'(cmd_valid), 1);
      if (cmd_valid && !rdy) begin
        if (held_v) chk(cmd_byte == held_b, {"R10 stall hold ", tag}, int'(cmd_byte), int'(held_b));
        held_b = cmd_byte; held_v = 1'b1;
      end else begin
        held_v = 1'b0;
      end
      cmd_ready = rdy;
      if (cmd_valid && rdy) begin
        chk(cmd_byte == exp_b[idx] && cmd_is_cmd == exp_c[idx],
            {"R6/R7/R8 byte ", tag}, int'({cmd_is_cmd, cmd_byte}), int'({exp_c[idx], exp_b[idx]}));
        idx++;
      end
      @(negedge clk);
      cyc++;
    end
    cmd_ready = 1'b0;
    req_valid = 1'b0;
    chk(idx == exp_n, {"R10 count ", tag}, idx, exp_n);
    chk(busy == 1'b0 && req_ready == 1'b1, {"R11 idle after ", tag}, int'(busy), 0);
    if (inject) begin
      for (int k = 0; k < 3; k++) begin
        chk(cmd_valid == 1'b0, {"R2 no extra stream ", tag}, int'(cmd_valid), 0);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    chk(busy == 1'b0 && cmd_valid == 1'b0 && req_ready == 1'b1, "R1 reset state",
        int'({busy, cmd_valid, req_ready}), 1);
  endtask

  task automatic t_first();       // R3 R4 R6 R7 R8
    run_req(8'd10, 8'd100, 8'd20, 8'd200, 2'd0, 1'b0, 0, 1'b0, "first");
  endtask

  task automatic t_same_orient(); // R5 R10
    run_req(8'd0, 8'd175, 8'd0, 8'd219, 2'd0, 1'b0, 1, 1'b0, "same-orient");
  endtask

  task automatic t_rotations();   // R4 R5
    for (int r = 1; r < 4; r++) run_req(8'd5, 8'd6, 8'd7, 8'd8, 2'(r), 1'b1, 0, 1'b0, "rotation");
    run_req(8'd5, 8'd6, 8'd7, 8'd8, 2'd3, 1'b0, 0, 1'b0, "bgr-only change");
  endtask

  task automatic t_clamp();       // R9
    run_req(8'd200, 8'd255, 8'd230, 8'd250, 2'd3, 1'b0, 0, 1'b0, "clamp");
    run_req(8'd175, 8'd176, 8'd219, 8'd220, 2'd3, 1'b0, 0, 1'b0, "clamp edge");
  endtask

  task automatic t_ignore();      // R2
    run_req(8'd30, 8'd40, 8'd50, 8'd60, 2'd3, 1'b0, 0, 1'b1, "busy request");
  endtask

  task automatic t_back_pressure(); // R10
    run_req(8'd11, 8'd22, 8'd33, 8'd44, 2'd2, 1'b1, 2, 1'b0, "stall");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first();
    t_same_orient();
    t_rotations();
    t_clamp();
    t_ignore();
    t_back_pressure();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule